// File: doc/BRIEF.md
# Poison Range Query Engine

The engine answers a query against a table of poisoned memory ranges. A query gives a start byte address and a window length counted in 64-byte lines. The engine reads the stored ranges one by one through an indexed read port. Each entry holds a start address, a byte length and a 3-bit poison type. It then builds a reply in a byte-wide payload buffer: a 32-byte header, followed by one 16-byte record for each stored range that overlaps the window. Each record is clipped to the window.

Use is one command at a time. The caller presents the query, the number of valid table entries and the overflow state (a flag and a 64-bit timestamp), then pulses `start`. The engine first clears the whole reply buffer. It then scans the table and emits records in table index order, and writes the header last, once the record count is known. It finishes with a one-cycle `done` pulse carrying a return code and the reply length in bytes.

Top module: `pq_engine`

## Requirements
- R1: A query whose start address has any of bits 5:0 set is rejected. `done` rises on the cycle after `start`, `ret_code` is 0x0002 and `out_len` is 0. No buffer byte is written.
- R2: The query window runs from the start address up to, but not including, start + 64 × `q_lines`.
- R3: A table entry is skipped when its start is at or beyond the window end, or when its start plus its length is at or before the window start. Records appear in ascending table index order.
- R4: The clipped start of a record is the larger of the entry start rounded down to a multiple of 64 and the window start. The clipped stop is the smaller of (rounded entry start + entry length) and the window end.
- R5: Record k occupies bytes 32+16k to 47+16k, all little-endian. Bytes 0-7 hold the clipped start ORed with the entry type in bits 2:0. Bytes 8-11 hold (stop − start)/64. Bytes 12-15 are zero.
- R6: Every buffer byte from 0 to BUF_BYTES−1 is written to zero before any non-zero byte is written. Bytes not covered by the header or a record end up zero.
- R7: Header layout: byte 0 is flags, with bit 1 equal to the overflow flag and all other bits zero. Byte 1 is zero. Bytes 2-9 hold the overflow timestamp, little-endian, when the flag is set, and zero otherwise. Bytes 10-11 hold the record count, little-endian. Bytes 12-31 are zero.
- R8: A valid query completes with a single-cycle `done`, `ret_code` 0x0000 and `out_len` = 32 + 16 × record count.
- R9: The engine reads entries 0 to n−1 through `tbl_idx`, taking the read data in the same cycle. Here n is `n_entries` clamped to MAX_REC.
- R10: After reset, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a query (honoured while idle) |
| q_addr | input | ADDR_W | Query start byte address |
| q_lines | input | QLEN_W | Query length in 64-byte lines |
| n_entries | input | CNT_W | Number of valid table entries |
| ovf_flag | input | 1 | Poison list has overflowed |
| ovf_ts | input | TS_W | Overflow timestamp |
| tbl_idx | output | CNT_W | Table read index |
| tbl_start | input | ADDR_W | Entry start address at `tbl_idx` |
| tbl_len | input | ELEN_W | Entry length in bytes at `tbl_idx` |
| tbl_type | input | 3 | Entry poison type at `tbl_idx` |
| wr_en | output | 1 | Buffer byte write strobe |
| wr_addr | output | BA_W | Buffer byte address |
| wr_data | output | 8 | Buffer byte data |
| done | output | 1 | Query complete pulse |
| ret_code | output | 16 | Return code, valid with `done` |
| out_len | output | OL_W | Reply length in bytes, valid with `done` |

## Verification
The assertions assume that `start` arrives only while the engine is idle. They also assume that the table holds its contents steady for the length of a query and answers reads in the same cycle. The bench waits for each `done` before it issues the next query. It models the table as arrays indexed straight from `tbl_idx` and leaves the arrays untouched while a query runs. The entries in the bench are kept so that a rounded entry start never falls more than one entry length below the window start. This keeps every clipped span non-negative.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int CW        = 96;
  localparam int HDR_BYTES = 32;
  localparam int REC_BYTES = 16;
  localparam int LINE_SH   = 6;

  typedef logic [CW-1:0] calc_t;

  typedef enum logic [15:0] {
    RC_SUCCESS   = 16'h0000,
    RC_BAD_INPUT = 16'h0002
  } rc_e;

  typedef enum logic [2:0] {S_IDLE, S_ZERO, S_SCAN, S_EMIT, S_HDR} st_e;

  function automatic calc_t win_end(calc_t s, calc_t lines);
    return s + (lines << LINE_SH);
  endfunction

  function automatic logic ranges_meet(calc_t es, calc_t el, calc_t qs, calc_t qe);
    return !((es >= qe) || ((es + el) <= qs));
  endfunction

  function automatic calc_t line_floor(calc_t a);
    return a & ~calc_t'(63);
  endfunction

  function automatic calc_t clip_lo(calc_t es, calc_t qs);
    calc_t r = line_floor(es);
    return (r > qs) ? r : qs;
  endfunction

  function automatic calc_t clip_hi(calc_t es, calc_t el, calc_t qe);
    calc_t r = line_floor(es) + el;
    return (r < qe) ? r : qe;
  endfunction

  function automatic logic [31:0] span_lines(calc_t lo, calc_t hi);
    calc_t d = (hi - lo) >> LINE_SH;
    return d[31:0];
  endfunction
endpackage

// File: rtl/pq_clip.sv
module pq_clip
  import pq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ELEN_W = 32
) (
  input  calc_t              q_lo,
  input  calc_t              q_hi,
  input  logic [ADDR_W-1:0]  e_start,
  input  logic [ELEN_W-1:0]  e_len,
  input  logic [2:0]         e_type,
  output logic               hit,
  output logic [127:0]       rec_word
);
  calc_t es, el, lo, hi;
  logic [63:0] addr_f;
  logic [31:0] lines_f;

  always_comb begin
    es      = calc_t'(e_start);
    el      = calc_t'(e_len);
    hit     = ranges_meet(es, el, q_lo, q_hi);
    lo      = clip_lo(es, q_lo);
    hi      = clip_hi(es, el, q_hi);
    addr_f  = lo[63:0] | {61'b0, e_type};
    lines_f = span_lines(lo, hi);
    rec_word = {32'h0, lines_f, addr_f};
  end
endmodule

// File: rtl/pq_pack.sv
module pq_pack #(
  parameter int LANES = 16,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] word,
  input  logic [SEL_W-1:0]   sel,
  output logic [7:0]         byte_o
);
  logic [7:0] lane [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[8*g +: 8];
  end
  assign byte_o = lane[sel];
endmodule

// File: rtl/pq_engine.sv
module pq_engine
  import pq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int QLEN_W  = 16,
  parameter int ELEN_W  = 32,
  parameter int TS_W    = 64,
  parameter int MAX_REC = 8,
  localparam int CNT_W     = $clog2(MAX_REC + 1),
  localparam int BUF_BYTES = HDR_BYTES + REC_BYTES * MAX_REC,
  localparam int BA_W      = $clog2(BUF_BYTES),
  localparam int OL_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [QLEN_W-1:0] q_lines,
  input  logic [CNT_W-1:0]  n_entries,
  input  logic              ovf_flag,
  input  logic [TS_W-1:0]   ovf_ts,
  output logic [CNT_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_start,
  input  logic [ELEN_W-1:0] tbl_len,
  input  logic [2:0]        tbl_type,
  output logic              wr_en,
  output logic [BA_W-1:0]   wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic [15:0]       ret_code,
  output logic [OL_W-1:0]   out_len
);
  st_e               st;
  rc_e               rc_q;
  logic [BA_W-1:0]   ptr;
  logic [CNT_W-1:0]  idx, rec_cnt, n_q;
  logic [ADDR_W-1:0] qs_q;
  logic [QLEN_W-1:0] ql_q;
  logic              ovf_q, zeroed_q;
  logic [TS_W-1:0]   ts_q;
  logic [127:0]      rec_q, rec_word, hdr_word, pack_word;
  logic [OL_W-1:0]   out_len_q;
  logic              hit;
  logic [7:0]        pack_byte;
  calc_t             q_lo, q_hi;

  // named internal events for the checker
  logic eng_idle, tbl_rd, q_misaligned, zero_fill_done;
  assign eng_idle       = (st == S_IDLE);
  assign tbl_rd         = (st == S_SCAN) && (idx != n_q);
  assign q_misaligned   = (q_addr[5:0] != 6'd0);
  assign zero_fill_done = zeroed_q;

  assign q_lo = calc_t'(qs_q);
  assign q_hi = win_end(q_lo, calc_t'(ql_q));

  pq_clip #(.ADDR_W(ADDR_W), .ELEN_W(ELEN_W)) u_clip (
    .q_lo(q_lo), .q_hi(q_hi), .e_start(tbl_start), .e_len(tbl_len),
    .e_type(tbl_type), .hit(hit), .rec_word(rec_word)
  );

  assign hdr_word = {32'h0, 16'(rec_cnt), (ovf_q ? 64'(ts_q) : 64'h0),
                     8'h00, (ovf_q ? 8'h02 : 8'h00)};
  assign pack_word = (st == S_HDR) ? hdr_word : rec_q;

  pq_pack #(.LANES(REC_BYTES)) u_pack (
    .word(pack_word), .sel(ptr[3:0]), .byte_o(pack_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; rc_q <= RC_SUCCESS; ptr <= '0; idx <= '0;
      rec_cnt <= '0; n_q <= '0; qs_q <= '0; ql_q <= '0; ovf_q <= 1'b0;
      ts_q <= '0; rec_q <= '0; out_len_q <= '0; zeroed_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          qs_q <= q_addr; ql_q <= q_lines; ovf_q <= ovf_flag; ts_q <= ovf_ts;
          n_q <= (n_entries > CNT_W'(MAX_REC)) ? CNT_W'(MAX_REC) : n_entries;
          ptr <= '0; idx <= '0; rec_cnt <= '0; zeroed_q <= 1'b0;
          if (q_misaligned) begin
            done <= 1'b1; rc_q <= RC_BAD_INPUT; out_len_q <= '0;
          end else begin
            st <= S_ZERO;
          end
        end
        S_ZERO: if (ptr == BA_W'(BUF_BYTES - 1)) begin
          st <= S_SCAN; ptr <= '0; zeroed_q <= 1'b1;
        end else ptr <= ptr + 1'b1;
        S_SCAN: if (idx == n_q) begin
          st <= S_HDR; ptr <= '0;
        end else if (hit) begin
          rec_q <= rec_word; st <= S_EMIT; ptr <= '0;
        end else idx <= idx + 1'b1;
        S_EMIT: if (ptr == BA_W'(REC_BYTES - 1)) begin
          rec_cnt <= rec_cnt + 1'b1; idx <= idx + 1'b1; st <= S_SCAN;
        end else ptr <= ptr + 1'b1;
        S_HDR: if (ptr == BA_W'(REC_BYTES - 1)) begin
          st <= S_IDLE; done <= 1'b1; rc_q <= RC_SUCCESS;
          out_len_q <= OL_W'(HDR_BYTES + REC_BYTES * int'(rec_cnt));
        end else ptr <= ptr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = ptr;
    wr_data = 8'h00;
    case (st)
      S_ZERO: wr_en = 1'b1;
      S_EMIT: begin
        wr_en   = 1'b1;
        wr_addr = BA_W'(HDR_BYTES + REC_BYTES * int'(rec_cnt) + int'(ptr));
        wr_data = pack_byte;
      end
      S_HDR: begin
        wr_en   = 1'b1;
        wr_data = pack_byte;
      end
      default: ;
    endcase
  end

  assign tbl_idx  = idx;
  assign ret_code = 16'(rc_q);
  assign out_len  = out_len_q;
endmodule

// File: rtl/pq_engine_chk.sv
module pq_engine_chk #(
  parameter int BUF_BYTES = 160,
  parameter int BA_W      = 8,
  parameter int OL_W      = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            eng_idle,
  input logic            q_misaligned,
  input logic            tbl_rd,
  input logic            zero_fill_done,
  input logic            wr_en,
  input logic [BA_W-1:0] wr_addr,
  input logic [7:0]      wr_data,
  input logic            done,
  input logic [15:0]     ret_code,
  input logic [OL_W-1:0] out_len
);
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && eng_idle && q_misaligned) |=> (done && ret_code == 16'h0002 && out_len == '0 && !wr_en));

  p_zero_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != 8'h00) |-> zero_fill_done);

  p_wr_in_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < BUF_BYTES));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_len_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ret_code == 16'h0000) |-> (int'(out_len) >= 32 && out_len[3:0] == 4'd0 && int'(out_len) <= BUF_BYTES));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> (!wr_en && !tbl_rd));
endmodule

bind pq_engine pq_engine_chk #(.BUF_BYTES(BUF_BYTES), .BA_W(BA_W), .OL_W(OL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .eng_idle(eng_idle),
  .q_misaligned(q_misaligned), .tbl_rd(tbl_rd), .zero_fill_done(zero_fill_done),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
  .ret_code(ret_code), .out_len(out_len)
);

// File: tb/pq_engine_tb.sv
`timescale 1ns/1ps
module pq_engine_tb;
  localparam int MAXR  = 4;
  localparam int BUFB  = 32 + 16 * MAXR;
  localparam int CNTW  = $clog2(MAXR + 1);
  localparam int BAW   = $clog2(BUFB);
  localparam int OLW   = $clog2(BUFB + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] q_addr = '0;
  logic [15:0] q_lines = '0;
  logic [CNTW-1:0] n_entries = '0;
  logic ovf_flag = 1'b0;
  logic [63:0] ovf_ts = '0;
  logic [CNTW-1:0] tbl_idx;
  logic [31:0] tbl_start, tbl_len;
  logic [2:0] tbl_type;
  logic wr_en, done;
  logic [BAW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [15:0] ret_code;
  logic [OLW-1:0] out_len;

  logic [31:0] t_start [0:7];
  logic [31:0] t_len   [0:7];
  logic [2:0]  t_type  [0:7];
  assign tbl_start = t_start[tbl_idx];
  assign tbl_len   = t_len[tbl_idx];
  assign tbl_type  = t_type[tbl_idx];

  pq_engine #(.MAX_REC(MAXR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .q_addr(q_addr), .q_lines(q_lines),
    .n_entries(n_entries), .ovf_flag(ovf_flag), .ovf_ts(ovf_ts), .tbl_idx(tbl_idx),
    .tbl_start(tbl_start), .tbl_len(tbl_len), .tbl_type(tbl_type), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .ret_code(ret_code), .out_len(out_len)
  );

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [7:0] mem [0:BUFB-1];
  logic [7:0] exp_mem [0:BUFB-1];
  int exp_len, nwr, lat;
  logic [15:0] got_rc;
  int got_len;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // Bench model of the reply, written from the requirements.
  task automatic model(input longint unsigned qs, input int lines, input int n,
                       input bit ovf, input longint unsigned ts);
    longint unsigned qe, es, el, base, lo, hi, addr, cnt;
    int used;
    qe = qs + 64 * longint'(lines);
    used = (n > MAXR) ? MAXR : n;
    for (int i = 0; i < BUFB; i++) exp_mem[i] = 8'h00;
    cnt = 0;
    for (int i = 0; i < used; i++) begin
      es = t_start[i]; el = t_len[i];
      if (es < qe && es + el > qs) begin
        base = es - (es % 64);
        lo   = (base > qs) ? base : qs;
        hi   = (base + el < qe) ? base + el : qe;
        addr = lo + t_type[i];
        for (int b = 0; b < 8; b++) exp_mem[32 + 16*cnt + b] = 8'((addr >> (8*b)) & 255);
        for (int b = 0; b < 4; b++) exp_mem[32 + 16*cnt + 8 + b] = 8'((((hi - lo) / 64) >> (8*b)) & 255);
        cnt++;
      end
    end
    exp_mem[0] = ovf ? 8'h02 : 8'h00;
    for (int b = 0; b < 8; b++) exp_mem[2 + b] = ovf ? 8'((ts >> (8*b)) & 255) : 8'h00;
    exp_mem[10] = 8'(cnt & 255);
    exp_mem[11] = 8'((cnt >> 8) & 255);
    exp_len = 32 + 16 * int'(cnt);
  endtask

  task automatic run_query(input longint unsigned qs, input int lines, input int n,
                           input bit ovf, input longint unsigned ts);
    for (int i = 0; i < BUFB; i++) mem[i] = 8'hA5;
    nwr = 0; lat = 0;
    @(negedge clk);
    q_addr = 32'(qs); q_lines = 16'(lines); n_entries = CNTW'(n);
    ovf_flag = ovf; ovf_ts = ts; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 2000) begin
      if (wr_en) begin mem[wr_addr] = wr_data; nwr++; end
      @(negedge clk);
      lat++;
    end
    got_rc = ret_code; got_len = int'(out_len);
  endtask

  task automatic check_reply(input string tag);
    int bad_h, bad_r, bad_t, ih, ir, it;
    bad_h = 0; bad_r = 0; bad_t = 0; ih = 0; ir = 0; it = 0;
    for (int i = 0; i < BUFB; i++) if (mem[i] !== exp_mem[i]) begin
      if (i < 32) begin if (bad_h == 0) ih = i; bad_h++; end
      else if (i < exp_len) begin if (bad_r == 0) ir = i; bad_r++; end
      else begin if (bad_t == 0) it = i; bad_t++; end
    end
    chk(got_rc == 16'h0000, "R8", {tag, " ret_code"}, got_rc, 0);
    chk(got_len == exp_len, "R8", {tag, " out_len"}, got_len, exp_len);
    chk(bad_h == 0, "R7", {tag, " header byte"}, mem[ih], exp_mem[ih]);
    chk(bad_r == 0, "R2 R3 R4 R5", {tag, " record byte"}, mem[ir], exp_mem[ir]);
    chk(bad_t == 0, "R6", {tag, " unused byte"}, mem[it], exp_mem[it]);
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin t_start[i] = '0; t_len[i] = '0; t_type[i] = '0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!done && !wr_en, "R10", "outputs in reset", {done, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !wr_en, "R10", "outputs after reset", {done, wr_en}, 0);

    // Sweep table: aligned ranges with distinct types
    t_start[0] = 32'h080; t_len[0] = 32'h080; t_type[0] = 3'd1;
    t_start[1] = 32'h200; t_len[1] = 32'h040; t_type[1] = 3'd5;
    t_start[2] = 32'h240; t_len[2] = 32'h100; t_type[2] = 3'd7;
    t_start[3] = 32'h3C0; t_len[3] = 32'h040; t_type[3] = 3'd2;

    // R1: misaligned starts
    foreach (t_type[k]) if (k < 3) begin
      longint unsigned bad;
      bad = (k == 0) ? 64'h201 : (k == 1) ? 64'h220 : 64'h23F;
      run_query(bad, 4, 4, 1'b1, 64'h55);
      chk(got_rc == 16'h0002, "R1", "reject code", got_rc, 2);
      chk(got_len == 0, "R1", "reject length", got_len, 0);
      chk(nwr == 0 && lat == 0, "R1", "reject writes/latency", nwr * 16 + lat, 0);
      chk(mem[0] == 8'hA5, "R1", "buffer untouched", mem[0], 8'hA5);
    end

    // R2..R8: sweep window start and length over the table
    for (int s = 0; s <= 16; s++) begin
      for (int l = 0; l <= 6; l++) begin
        bit ov;
        ov = ((s + l) % 3 == 0);
        model(64 * s, l, 4, ov, 64'h1122334455667788 + s);
        run_query(64 * s, l, 4, ov, 64'h1122334455667788 + s);
        check_reply("sweep");
      end
    end

    // R8: empty table gives a header only
    model(64'h100, 8, 0, 1'b0, 0);
    run_query(64'h100, 8, 0, 1'b0, 0);
    check_reply("empty");

    // R4: unaligned entry start is rounded down before clipping
    t_start[0] = 32'h1050; t_len[0] = 32'h40; t_type[0] = 3'd3;
    model(64'h1000, 4, 1, 1'b0, 0);
    run_query(64'h1000, 4, 1, 1'b0, 0);
    check_reply("unaligned entry");

    // R9: entry count above MAX_REC is clamped
    for (int i = 0; i < 6; i++) begin
      t_start[i] = 32'(32'h2000 + 32'h80 * i); t_len[i] = 32'h40; t_type[i] = 3'(i);
    end
    model(64'h2000, 16'hFFFF, 6, 1'b1, 64'hDEADBEEF00C0FFEE);
    run_query(64'h2000, 16'hFFFF, 6, 1'b1, 64'hDEADBEEF00C0FFEE);
    check_reply("R9 clamp");
    chk(got_len == BUFB, "R9", "clamped length", got_len, BUFB);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule